// File: doc/BRIEF.md
# UART Modem Handshake and Flow Control

This block is the modem handshake side of a UART. It samples four handshake inputs from the line side (clear to send, data set ready, ring indicator and carrier detect), keeps a sticky change flag for each of them, and raises a modem-status interrupt while any flag is pending. It also drives the two handshake outputs, data terminal ready and request to send. Software reaches three registers through a simple write port and a combinational read port: a read-only status word, a read/write control word and a flow-threshold word.

When automatic flow control is off, which is the state after reset, both outputs simply follow the control word. When it is on, request to send is driven by the block from the receive FIFO fill level. It drops as soon as the level reaches the programmed threshold and comes back only after the level has fallen four entries below it. In the same mode, clear to send gates the transmitter through a permission output. That output only changes between characters, so a character that has already started always completes.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset, DTR and RTS outputs are 0, the control word reads 0, the status word reads 0, the interrupt output is 0, the transmit permission output is 1 and the threshold word reads 32.
- R2: The status word (address 0) shows the synchronized input levels in bits 4 (clear to send), 5 (data set ready), 6 (ring indicator) and 7 (carrier detect), and the automatic-mode enable in bit 8; a level change appears there two clock edges after it reaches the pin.
- R3: Either edge of an input sets its change flag (status bits 0 to 3, same input order as bits 4 to 7) on the third clock edge after the pin changes; the interrupt output is high exactly while any change flag is set.
- R4: Writing the status address with a 1 in bits 0 to 3 clears those flags; a 0 leaves a flag unchanged; if a new edge sets a flag on the same edge as its clear, the flag stays set.
- R5: The control word (address 1) holds DTR in bit 0, RTS in bit 1 and the automatic-mode enable in bit 4, reads back as written, and with automatic mode off DTR and RTS outputs follow bits 0 and 1 after one edge.
- R6: With automatic mode on, RTS goes low on the edge after the FIFO level is at or above the threshold, stays low while the level is above threshold minus four, and returns high on the edge after the level is at or below threshold minus four.
- R7: If the threshold is below four, the return level saturates at zero, so RTS returns high only when the FIFO level is zero.
- R8: The flow-level output is high, in the same cycle, exactly when the FIFO level is at or above the threshold, whether or not automatic mode is on.
- R9: With automatic mode on, the transmit permission output takes the synchronized clear-to-send level, updated only on edges where the transmitter is not busy; with automatic mode off it is 1 whenever the transmitter is not busy.
- R10: The threshold word (address 2) holds the threshold in bits 5:0 and reads back as written; address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cts_i | input | 1 | Clear to send, asynchronous |
| dsr_i | input | 1 | Data set ready, asynchronous |
| ri_i | input | 1 | Ring indicator, asynchronous |
| dcd_i | input | 1 | Carrier detect, asynchronous |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| msi_o | output | 1 | Modem-status interrupt |
| rx_level_i | input | 6 | Receive FIFO fill level |
| flow_del_o | output | 1 | FIFO level at or above threshold |
| tx_busy_i | input | 1 | Transmitter is sending a character |
| tx_allow_o | output | 1 | Transmitter may load a new character |

## Verification
Register writes and the RTS decision take effect one edge after they are presented, the flow-level output and read data are due in the same cycle, an input level shows in the status word two edges after the pin moves, its change flag three edges after, and transmit permission three edges after clear to send moves while the transmitter is idle. The bench drives every input one time unit after a rising edge and samples at that same point, so each check is placed after exactly the number of edges listed above. The random flow-control phase updates its hysteresis model once per edge from the level presented before that edge and compares RTS after it. The coincident set-and-clear case times the write to land on the very edge where the second input toggle is detected.

// File: rtl/modem_pkg.sv
package modem_pkg;

    localparam int NUM_IN = 4;

    // Input order shared by status levels and change flags
    localparam int IN_CTS = 0;
    localparam int IN_DSR = 1;
    localparam int IN_RI  = 2;
    localparam int IN_DCD = 3;

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_FDEL = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // Status word layout
    localparam int STAT_CHG_LSB = 0;
    localparam int STAT_LVL_LSB = 4;
    localparam int STAT_FCM_BIT = 8;

    // Control word layout
    localparam int CTRL_DTR_BIT = 0;
    localparam int CTRL_RTS_BIT = 1;
    localparam int CTRL_FCM_BIT = 4;

    // Distance between drop level and return level
    localparam int REARM_GAP = 4;

    typedef struct packed {
        logic fcm;
        logic rts;
        logic dtr;
    } ctrl_t;

endpackage

// File: rtl/modem_in_sync.sv
module modem_in_sync
    import modem_pkg::*;
#(
    parameter int N = NUM_IN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] edge_o
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic s1_q, s2_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin_i[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign level_o[i] = s2_q;
        assign edge_o[i]  = s2_q ^ prev_q;
    end

endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl
    import modem_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fcm_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] fdel_i,
    output logic             hold_o,
    output logic             flowdel_o
);

    localparam logic [LVL_W-1:0] GAP = LVL_W'(REARM_GAP);

    logic [LVL_W-1:0] rearm;
    logic             at_trip;
    logic             at_rearm;
    logic             hold_q;

    always_comb begin
        rearm    = (fdel_i >= GAP) ? (fdel_i - GAP) : '0;
        at_trip  = (level_i >= fdel_i);
        at_rearm = (level_i <= rearm);
    end

    always_ff @(posedge clk) begin
        if (rst || !fcm_i) begin
            hold_q <= 1'b0;
        end else if (at_trip) begin
            hold_q <= 1'b1;
        end else if (at_rearm) begin
            hold_q <= 1'b0;
        end
    end

    assign hold_o    = hold_q;
    assign flowdel_o = at_trip;

endmodule

// File: rtl/tx_gate.sv
module tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic fcm_i,
    input  logic cts_i,
    input  logic tx_busy_i,
    output logic tx_allow_o
);

    logic allow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            allow_q <= 1'b1;
        end else if (!tx_busy_i) begin
            allow_q <= fcm_i ? cts_i : 1'b1;
        end
    end

    assign tx_allow_o = allow_q;

endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
    import modem_pkg::*;
#(
    parameter int LVL_W    = 6,
    parameter int DW       = 16,
    parameter int FDEL_RST = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             cts_i,
    input  logic             dsr_i,
    input  logic             ri_i,
    input  logic             dcd_i,
    output logic             dtr_o,
    output logic             rts_o,
    output logic             msi_o,
    input  logic [LVL_W-1:0] rx_level_i,
    output logic             flow_del_o,
    input  logic             tx_busy_i,
    output logic             tx_allow_o
);

    logic [NUM_IN-1:0] pins;
    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] edg;
    logic [NUM_IN-1:0] chg_q;
    logic [NUM_IN-1:0] clr_mask;
    ctrl_t             ctrl_q;
    logic [LVL_W-1:0]  fdel_q;
    logic              hold;
    reg_addr_e         waddr;
    reg_addr_e         raddr;

    assign pins  = {dcd_i, ri_i, dsr_i, cts_i};
    assign waddr = reg_addr_e'(wr_addr);
    assign raddr = reg_addr_e'(rd_addr);

    modem_in_sync #(.N(NUM_IN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pins),
        .level_o (lvl),
        .edge_o  (edg)
    );

    // Write-one-to-clear; a fresh edge wins over a clear
    assign clr_mask = (wr_en && waddr == ADDR_STAT)
                    ? wr_data[STAT_CHG_LSB +: NUM_IN] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            chg_q <= '0;
        end else begin
            chg_q <= (chg_q & ~clr_mask) | edg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            fdel_q <= LVL_W'(FDEL_RST);
        end else if (wr_en) begin
            case (waddr)
                ADDR_CTRL: begin
                    ctrl_q.dtr <= wr_data[CTRL_DTR_BIT];
                    ctrl_q.rts <= wr_data[CTRL_RTS_BIT];
                    ctrl_q.fcm <= wr_data[CTRL_FCM_BIT];
                end
                ADDR_FDEL: fdel_q <= wr_data[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    flow_rts_ctrl #(.LVL_W(LVL_W)) u_flow (
        .clk       (clk),
        .rst       (rst),
        .fcm_i     (ctrl_q.fcm),
        .level_i   (rx_level_i),
        .fdel_i    (fdel_q),
        .hold_o    (hold),
        .flowdel_o (flow_del_o)
    );

    tx_gate u_txg (
        .clk        (clk),
        .rst        (rst),
        .fcm_i      (ctrl_q.fcm),
        .cts_i      (lvl[IN_CTS]),
        .tx_busy_i  (tx_busy_i),
        .tx_allow_o (tx_allow_o)
    );

    assign dtr_o = ctrl_q.dtr;
    assign rts_o = ctrl_q.fcm ? !hold : ctrl_q.rts;
    assign msi_o = |chg_q;

    always_comb begin
        rd_data = '0;
        case (raddr)
            ADDR_STAT: begin
                rd_data[STAT_CHG_LSB +: NUM_IN] = chg_q;
                rd_data[STAT_LVL_LSB +: NUM_IN] = lvl;
                rd_data[STAT_FCM_BIT]           = ctrl_q.fcm;
            end
            ADDR_CTRL: begin
                rd_data[CTRL_DTR_BIT] = ctrl_q.dtr;
                rd_data[CTRL_RTS_BIT] = ctrl_q.rts;
                rd_data[CTRL_FCM_BIT] = ctrl_q.fcm;
            end
            ADDR_FDEL: rd_data[LVL_W-1:0] = fdel_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/modem_ctrl_chk.sv
module modem_ctrl_chk #(
    parameter int LVL_W = 6,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic [3:0]       chg,
    input logic             fcm,
    input logic [LVL_W-1:0] fdel,
    input logic [LVL_W-1:0] rx_level_i,
    input logic             rts_o,
    input logic             tx_busy_i,
    input logic             tx_allow_o
);

    logic [LVL_W-1:0] ref_rearm;
    assign ref_rearm = (fdel > LVL_W'(3)) ? fdel - LVL_W'(4) : '0;

    assert_rts_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (fcm && !wr_en && rx_level_i >= fdel) |=> !rts_o);

    assert_rts_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (fcm && !wr_en && !rts_o && rx_level_i > ref_rearm) |=> !rts_o);

    assert_chg_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == 2'd0) |=> (($past(chg) & ~chg) == 4'd0));

    assert_tx_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        tx_busy_i |=> $stable(tx_allow_o));

    assert_tx_free_R9: assert property (@(posedge clk) disable iff (rst)
        (!fcm && !tx_busy_i) |=> tx_allow_o);

endmodule

bind uart_modem_ctrl modem_ctrl_chk #(.LVL_W(LVL_W), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .chg        (chg_q),
    .fcm        (ctrl_q.fcm),
    .fdel       (fdel_q),
    .rx_level_i (rx_level_i),
    .rts_o      (rts_o),
    .tx_busy_i  (tx_busy_i),
    .tx_allow_o (tx_allow_o)
);

// File: tb/sim_uart_modem_ctrl.sv
module sim_uart_modem_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
    logic dtr_o, rts_o, msi_o, flow_del_o, tx_allow_o;
    logic [LVL_W-1:0] rx_level_i = '0;
    logic tx_busy_i = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctrl #(.LVL_W(LVL_W), .DW(DW), .FDEL_RST(32)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
        .dtr_o(dtr_o), .rts_o(rts_o), .msi_o(msi_o),
        .rx_level_i(rx_level_i), .flow_del_o(flow_del_o),
        .tx_busy_i(tx_busy_i), .tx_allow_o(tx_allow_o)
    );

    // Bench model state
    logic [3:0] m_lvl = '0;
    logic [3:0] m_chg = '0;
    logic       m_fcm = 1'b0;
    logic       m_hold = 1'b0;
    logic [LVL_W-1:0] m_fdel = 6'd32;

    function automatic logic [LVL_W-1:0] f_rearm(logic [LVL_W-1:0] t);
        return (int'(t) >= 4) ? LVL_W'(int'(t) - 4) : '0;
    endfunction

    function automatic logic f_hold(logic h, logic [LVL_W-1:0] l, logic [LVL_W-1:0] t);
        if (l >= t) return 1'b1;
        if (l <= f_rearm(t)) return 1'b0;
        return h;
    endfunction

    function automatic logic [DW-1:0] f_stat(logic [3:0] c, logic [3:0] v, logic f);
        logic [DW-1:0] s;
        s = '0;
        s[3:0] = c;
        s[7:4] = v;
        s[8] = f;
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_pins(logic [3:0] v);
        cts_i = v[0]; dsr_i = v[1]; ri_i = v[2]; dcd_i = v[3];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: act=timeout exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [3:0] nv;
        logic [3:0] mask;
        void'($urandom(32'd4242));

        tick(3);
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1 dtr", dtr_o, 0);
        check("R1 rts", rts_o, 0);
        check("R1 msi", msi_o, 0);
        check("R1 tx_allow", tx_allow_o, 1);
        rd(2'd1, d); check("R1 ctrl", d, 0);
        rd(2'd0, d); check("R1 stat", d, 0);
        rd(2'd2, d); check("R1 fdel", d, 32);

        // R5 control word with automatic mode off
        wr(2'd1, 16'h0001);
        check("R5 dtr on", dtr_o, 1);
        check("R5 rts off", rts_o, 0);
        rd(2'd1, d); check("R5 readback", d, 16'h0001);
        wr(2'd1, 16'h0002);
        check("R5 dtr off", dtr_o, 0);
        check("R5 rts on", rts_o, 1);

        // R10 threshold word and unused address
        wr(2'd2, 16'd20);
        m_fdel = 6'd20;
        rd(2'd2, d); check("R10 fdel readback", d, 20);
        rd(2'd3, d); check("R10 addr3", d, 0);

        // R8 flow level output, automatic mode off
        rx_level_i = 6'd20; #1;
        check("R8 at threshold", flow_del_o, 1);
        rx_level_i = 6'd19; #1;
        check("R8 below threshold", flow_del_o, 0);
        check("R5 rts unaffected by level", rts_o, 1);

        // R2 / R3 walk each input
        for (int i = 0; i < 4; i++) begin
            nv = m_lvl;
            nv[i] = 1'b1;
            set_pins(nv);
            tick(2);
            rd(2'd0, d); check("R2 level after two edges", d[7:4], nv);
            check("R3 flag not before third edge", d[i], 0);
            tick();
            m_chg[i] = 1'b1;
            m_lvl = nv;
            rd(2'd0, d); check("R3 flag set", d, f_stat(m_chg, m_lvl, m_fcm));
            check("R3 msi", msi_o, 1);
        end

        // R4 write zero leaves flags, clear all
        wr(2'd0, 16'h0000);
        rd(2'd0, d); check("R4 write zero", d[3:0], 4'hf);
        wr(2'd0, 16'h000f);
        m_chg = '0;
        rd(2'd0, d); check("R4 clear all", d[3:0], 0);
        check("R3 msi low", msi_o, 0);

        // R3 / R4 random input patterns and partial clears
        for (int k = 0; k < 24; k++) begin
            nv = 4'($urandom_range(0, 15));
            set_pins(nv);
            tick(4);
            m_chg = m_chg | (m_lvl ^ nv);
            m_lvl = nv;
            rd(2'd0, d); check("R3 random status", d, f_stat(m_chg, m_lvl, m_fcm));
            check("R3 random msi", msi_o, |m_chg);
            mask = 4'($urandom_range(0, 15));
            wr(2'd0, {12'd0, mask});
            m_chg = m_chg & ~mask;
            rd(2'd0, d); check("R4 random clear", d[3:0], m_chg);
        end

        // R4 set wins over same-edge clear on cts flag
        wr(2'd0, 16'h000f);
        m_chg = '0;
        nv = m_lvl; nv[0] = ~nv[0];
        set_pins(nv); tick(4);
        nv[0] = ~nv[0];
        set_pins(nv);
        tick(2);
        wr(2'd0, 16'h0001);
        m_lvl = nv;
        rd(2'd0, d); check("R4 set wins", d[0], 1);

        // R6 automatic flow control, directed
        wr(2'd1, 16'h0010);
        m_fcm = 1'b1;
        rd(2'd0, d); check("R2 fcm bit", d[8], 1);
        rx_level_i = 6'd19; tick();
        check("R6 below threshold", rts_o, 1);
        rx_level_i = 6'd20; tick();
        check("R6 drop at threshold", rts_o, 0);
        rx_level_i = 6'd17; tick();
        check("R6 held above rearm", rts_o, 0);
        rx_level_i = 6'd16; tick();
        check("R6 return at rearm", rts_o, 1);
        m_hold = 1'b0;

        // R6 random levels around the threshold
        for (int k = 0; k < 400; k++) begin
            rx_level_i = 6'($urandom_range(12, 26));
            #1;
            check("R8 random flow level", flow_del_o, rx_level_i >= m_fdel);
            m_hold = f_hold(m_hold, rx_level_i, m_fdel);
            tick();
            check("R6 random rts", rts_o, !m_hold);
        end

        // R7 small threshold saturates at zero
        rx_level_i = 6'd0; tick();
        wr(2'd2, 16'd2);
        m_fdel = 6'd2;
        rx_level_i = 6'd2; tick();
        check("R7 drop", rts_o, 0);
        rx_level_i = 6'd1; tick();
        check("R7 held at one", rts_o, 0);
        rx_level_i = 6'd0; tick();
        check("R7 return at zero", rts_o, 1);

        // R9 transmit gating on clear to send
        nv = m_lvl; nv[0] = 1'b1; set_pins(nv); tick(4);
        check("R9 allow with cts", tx_allow_o, 1);
        tx_busy_i = 1'b1;
        nv[0] = 1'b0; set_pins(nv);
        tick(5);
        check("R9 held during character", tx_allow_o, 1);
        tx_busy_i = 1'b0; tick();
        check("R9 paused at boundary", tx_allow_o, 0);
        nv[0] = 1'b1; set_pins(nv);
        tick(2);
        check("R9 not before sync", tx_allow_o, 0);
        tick();
        check("R9 resume", tx_allow_o, 1);
        nv[0] = 1'b0; set_pins(nv); tick(4);
        check("R9 cts low", tx_allow_o, 0);
        wr(2'd1, 16'h0000);
        tick();
        check("R9 mode off allows", tx_allow_o, 1);
        check("R5 rts follows word again", rts_o, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule